// File: doc/BRIEF.md
# Redundant Manchester Energy Frame Receiver

This block takes two copies of the same serial beam-energy stream, arriving on independent lines A and B, and produces one trusted 16-bit energy value. Each line carries Manchester-coded 32-bit frames. A frame holds a fixed start pattern, a toggle bit, the energy word and a CRC-8 check byte. Each line is decoded and checked on its own. A line counts as faulty after a rejected frame, or after a long enough silence, until it delivers a good frame again.

A fixed priority picks where the output comes from. Line A is used while it is healthy. Line B is used when only A is faulty. The last output is held when both are faulty. The sender flips the toggle bit at a slow, regular rate. If no flip is seen within the toggle window, the output is forced to full scale with the error flag raised, and this overrides every other case. Saturating counters record the faults of each line and each expiry of the toggle window. Timing is given in clock cycles by parameters: half-bit length, frame timeout and toggle timeout. With a 125 MHz clock these map to 1 Mbit/s, 3 ms and 110 ms.

Top module: `energy_link_rx`

## Requirements
- R1: Line coding: the line idles low. Each bit lasts 2*HALF_CYC clock cycles and is sent as two half-bits of opposite level: a 1 is high then low, a 0 is low then high. A frame is 32 bits, most significant bit first. If the two half-bits of a bit have the same level, the frame is rejected.
- R2: Frame layout, from bit 31 down to bit 0: the fixed pattern 1001000 in bits [31:25], the toggle bit at [24], the energy at [23:8], and the CRC at [7:0]. The CRC is CRC-8 with polynomial 0x07 and initial value 0x00, computed MSB first over bits [31:8]. A frame with a wrong pattern, a wrong CRC or a coding violation marks its line faulty and adds one to that line's error counter (err_cnt_a or err_cnt_b). A valid frame clears the line's faulty state and stores its energy.
- R3: If a line receives no valid frame for FRAME_TO_CYC cycles, it is marked faulty and its error counter is incremented. This repeats for each further FRAME_TO_CYC cycles of silence.
- R4: When there is no toggle timeout and line A is healthy, energy_o is A's last energy, src_o is 01 and err_o is 0.
- R5: When there is no toggle timeout, line A is faulty and line B is healthy, energy_o is B's last energy, src_o is 10 and err_o is 0.
- R6: When there is no toggle timeout and both lines are faulty, energy_o keeps its previous value, src_o is 00 and err_o is 0.
- R7: Each period of TOG_TO_CYC cycles without a valid frame whose toggle bit differs from the last one seen adds one to tog_cnt and starts the timeout. The first valid frame after reset counts as a change. While the timeout holds, energy_o is 0xFFFF, err_o is 1 and src_o is 11, whatever the state of the lines. The next valid frame with a changed toggle bit clears the timeout.
- R8: All three counters saturate at all-ones and never wrap.
- R9: After reset, energy_o is 0, err_o is 0, src_o is 00, all counters are 0, and both lines are faulty until their first valid frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_a | input | 1 | Serial line A, Manchester coded |
| line_b | input | 1 | Serial line B, Manchester coded |
| energy_o | output | 16 | Selected energy value |
| err_o | output | 1 | Toggle-timeout error flag |
| src_o | output | 2 | Source: 01 A, 10 B, 00 held, 11 forced full scale |
| err_cnt_a | output | CNT_W | Fault count of line A |
| err_cnt_b | output | CNT_W | Fault count of line B |
| tog_cnt | output | CNT_W | Toggle-timeout count |

## Verification
The bench sweeps walking-one energy words, plus all-zero and all-one words, through both lines. A decoder that swaps bit order or half-bit polarity would return the wrong words. Each fault type is applied to one line: a corrupted CRC, a wrong start pattern, a line cut in the middle of a frame, and silence on A alone. This catches a design that keeps using the bad line, counts a fault twice, or misses the timeout. Faults on both lines at once check that the output holds and is not overwritten. A long stretch of frames with a constant toggle bit, followed by total silence, checks the full-scale override, its exact count of expiries, its release on a changed toggle bit, and counter saturation with no wrap.

// File: rtl/energy_link_rx.sv
module energy_link_rx #(
  parameter int HALF_CYC     = 62,
  parameter int FRAME_TO_CYC = 375000,
  parameter int TOG_TO_CYC   = 13750000,
  parameter int CNT_W        = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             line_a,
  input  logic             line_b,
  output logic [15:0]      energy_o,
  output logic             err_o,
  output logic [1:0]       src_o,
  output logic [CNT_W-1:0] err_cnt_a,
  output logic [CNT_W-1:0] err_cnt_b,
  output logic [CNT_W-1:0] tog_cnt
);
  localparam int PW    = $clog2(2*HALF_CYC);
  localparam int SAMP1 = HALF_CYC/2 - 1;
  localparam int SAMP2 = SAMP1 + HALF_CYC;
  localparam int FW    = $clog2(FRAME_TO_CYC+1);
  localparam int TW    = $clog2(TOG_TO_CYC+1);

  function automatic logic [7:0] crc8(input logic [23:0] d);
    logic [7:0] c;
    logic fb;
    c = '0;
    for (int k = 23; k >= 0; k--) begin
      fb = c[7] ^ d[k];
      c  = {c[6:0], 1'b0} ^ (fb ? 8'h07 : 8'h00);
    end
    return c;
  endfunction

  logic             ln   [2];
  logic [2:0]       sy   [2];
  logic             busy [2];
  logic [PW-1:0]    ph   [2];
  logic [4:0]       bn   [2];
  logic             h1   [2];
  logic [31:0]      sh   [2];
  logic             done [2];
  logic             viol [2];
  logic             good [2];
  logic             bad  [2];
  logic [15:0]      eng  [2];
  logic [FW-1:0]    ft   [2];
  logic [CNT_W-1:0] ec   [2];

  assign ln[0] = line_a;
  assign ln[1] = line_b;

  for (genvar i = 0; i < 2; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        sy[i] <= '0; busy[i] <= 1'b0; ph[i] <= '0; bn[i] <= '0;
        h1[i] <= 1'b0; sh[i] <= '0; done[i] <= 1'b0; viol[i] <= 1'b0;
      end else begin
        sy[i]   <= {sy[i][1:0], ln[i]};
        done[i] <= 1'b0;
        viol[i] <= 1'b0;
        if (!busy[i]) begin
          if (sy[i][1] && !sy[i][2]) begin
            busy[i] <= 1'b1;
            ph[i]   <= PW'(1);
            bn[i]   <= '0;
          end
        end else begin
          ph[i] <= (ph[i] == PW'(2*HALF_CYC-1)) ? '0 : ph[i] + 1'b1;
          if (ph[i] == PW'(SAMP1)) h1[i] <= sy[i][1];
          if (ph[i] == PW'(SAMP2)) begin
            if (sy[i][1] == h1[i]) begin
              busy[i] <= 1'b0;
              viol[i] <= 1'b1;
            end else begin
              sh[i] <= {sh[i][30:0], h1[i]};
              if (bn[i] == 5'd31) begin
                busy[i] <= 1'b0;
                done[i] <= 1'b1;
              end else bn[i] <= bn[i] + 1'b1;
            end
          end
        end
      end

    assign good[i] = done[i] && (sh[i][31:25] == 7'b1001000) &&
                     (crc8(sh[i][31:8]) == sh[i][7:0]);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        bad[i] <= 1'b1; eng[i] <= '0; ft[i] <= '0; ec[i] <= '0;
      end else if (good[i]) begin
        bad[i] <= 1'b0;
        eng[i] <= sh[i][23:8];
        ft[i]  <= '0;
      end else begin
        ft[i] <= (ft[i] == FW'(FRAME_TO_CYC-1)) ? '0 : ft[i] + 1'b1;
        if (done[i] || viol[i] || ft[i] == FW'(FRAME_TO_CYC-1)) begin
          bad[i] <= 1'b1;
          if (ec[i] != {CNT_W{1'b1}}) ec[i] <= ec[i] + 1'b1;
        end
      end
  end

  assign err_cnt_a = ec[0];
  assign err_cnt_b = ec[1];

  logic          tv, tb, tseen, tref, tog_to;
  logic [TW-1:0] tt;
  assign tv = good[0] || good[1];
  assign tb = good[0] ? sh[0][24] : sh[1][24];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tseen <= 1'b0; tref <= 1'b0; tog_to <= 1'b0; tt <= '0; tog_cnt <= '0;
    end else if (tv && (!tseen || tb != tref)) begin
      tseen  <= 1'b1;
      tref   <= tb;
      tog_to <= 1'b0;
      tt     <= '0;
    end else if (tt == TW'(TOG_TO_CYC-1)) begin
      tt     <= '0;
      tog_to <= 1'b1;
      if (tog_cnt != {CNT_W{1'b1}}) tog_cnt <= tog_cnt + 1'b1;
    end else tt <= tt + 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      energy_o <= '0; err_o <= 1'b0; src_o <= 2'b00;
    end else if (tog_to) begin
      energy_o <= 16'hFFFF; err_o <= 1'b1; src_o <= 2'b11;
    end else if (!bad[0]) begin
      energy_o <= eng[0]; err_o <= 1'b0; src_o <= 2'b01;
    end else if (!bad[1]) begin
      energy_o <= eng[1]; err_o <= 1'b0; src_o <= 2'b10;
    end else begin
      err_o <= 1'b0; src_o <= 2'b00;
    end

  a_r4_prefer_a: assert property (@(posedge clk) disable iff (!rst_n)
    (!bad[0] && !tog_to) |=> (src_o == 2'b01 && energy_o == $past(eng[0])));
  a_r5_fallback_b: assert property (@(posedge clk) disable iff (!rst_n)
    (bad[0] && !bad[1] && !tog_to) |=> (src_o == 2'b10 && energy_o == $past(eng[1])));
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (bad[0] && bad[1] && !tog_to) |=> (src_o == 2'b00 && $stable(energy_o)));
  a_r7_forced: assert property (@(posedge clk) disable iff (!rst_n)
    tog_to |=> (energy_o == 16'hFFFF && err_o && src_o == 2'b11));
  a_r8_no_wrap_a: assert property (@(posedge clk) disable iff (!rst_n)
    (err_cnt_a == {CNT_W{1'b1}}) |=> (err_cnt_a == {CNT_W{1'b1}}));
  a_r8_no_wrap_t: assert property (@(posedge clk) disable iff (!rst_n)
    (tog_cnt == {CNT_W{1'b1}}) |=> (tog_cnt == {CNT_W{1'b1}}));
  a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((err_cnt_b - $past(err_cnt_b)) <= CNT_W'(1)));
endmodule

// File: tb/tb_energy_link_rx.sv
`timescale 1ns/1ps
module tb_energy_link_rx;
  localparam int H  = 4;
  localparam int CW = 4;

  logic clk = 1'b0, rst_n = 1'b0, la = 1'b0, lb = 1'b0;
  logic [15:0] energy_o;
  logic err_o;
  logic [1:0] src_o;
  logic [CW-1:0] err_cnt_a, err_cnt_b, tog_cnt;

  energy_link_rx #(.HALF_CYC(H), .FRAME_TO_CYC(1000), .TOG_TO_CYC(4000), .CNT_W(CW)) dut (
    .clk(clk), .rst_n(rst_n), .line_a(la), .line_b(lb), .energy_o(energy_o),
    .err_o(err_o), .src_o(src_o), .err_cnt_a(err_cnt_a), .err_cnt_b(err_cnt_b), .tog_cnt(tog_cnt));

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  logic finished = 1'b0;
  logic t = 1'b0;
  int ca = 0, cb = 0, ct = 0;

  function automatic logic [7:0] ref_crc(input logic [23:0] d);
    logic [7:0] c;
    c = 8'h00;
    for (int k = 23; k >= 0; k--)
      c = (c[7] ^ d[k]) ? ({c[6:0], 1'b0} ^ 8'h07) : {c[6:0], 1'b0};
    return c;
  endfunction

  function automatic logic [31:0] mkf(input logic [15:0] e, input logic tg,
                                      input logic bad_crc, input logic bad_hdr);
    logic [23:0] d;
    d = {(bad_hdr ? 7'b1011000 : 7'b1001000), tg, e};
    return {d, ref_crc(d) ^ (bad_crc ? 8'h01 : 8'h00)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_out(input string tag, input logic [15:0] e, input logic er, input logic [1:0] s);
    chk({tag, " energy"}, 32'(energy_o), 32'(e));
    chk({tag, " err"}, 32'(err_o), 32'(er));
    chk({tag, " src"}, 32'(src_o), 32'(s));
  endtask

  task automatic chk_cnt(input string tag);
    chk({tag, " cnt_a"}, 32'(err_cnt_a), 32'(ca > 15 ? 15 : ca));
    chk({tag, " cnt_b"}, 32'(err_cnt_b), 32'(cb > 15 ? 15 : cb));
    chk({tag, " tog_cnt"}, 32'(tog_cnt), 32'(ct > 15 ? 15 : ct));
  endtask

  task automatic send(input logic ena, input logic enb, input logic [31:0] fa,
                      input logic [31:0] fb, input int cut_a);
    for (int i = 31; i >= 0; i--) begin
      la = (ena && i > cut_a) ? fa[i] : 1'b0;
      lb = enb ? fb[i] : 1'b0;
      repeat (H) @(negedge clk);
      la = (ena && i > cut_a) ? ~fa[i] : 1'b0;
      lb = enb ? ~fb[i] : 1'b0;
      repeat (H) @(negedge clk);
    end
    la = 1'b0; lb = 1'b0;
    repeat (44) @(negedge clk);
  endtask

  task automatic good_both(input logic [15:0] v);
    t = ~t;
    send(1'b1, 1'b1, mkf(v, t, 1'b0, 1'b0), mkf(v ^ 16'h0F0F, t, 1'b0, 1'b0), -1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk_out("R9 reset", 16'h0000, 1'b0, 2'b00);
    chk_cnt("R9 reset");

    for (int k = 0; k < 18; k++) begin
      logic [15:0] v;
      v = (k < 16) ? (16'h1 << k) : ((k == 16) ? 16'h0000 : 16'hFFFF);
      good_both(v);
      chk_out("R1 R2 R4 sweep", v, 1'b0, 2'b01);
    end

    t = ~t;
    send(1'b1, 1'b1, mkf(16'h3C3C, t, 1'b1, 1'b0), mkf(16'h3333, t, 1'b0, 1'b0), -1);
    ca++;
    chk_out("R5 crc fault on A", 16'h3333, 1'b0, 2'b10);
    chk_cnt("R2 crc fault on A");
    good_both(16'h4444);
    chk_out("R4 A recovered", 16'h4444, 1'b0, 2'b01);

    t = ~t;
    send(1'b1, 1'b1, mkf(16'h5A5A, t, 1'b0, 1'b1), mkf(16'h5555, t, 1'b0, 1'b0), -1);
    ca++;
    chk_out("R5 header fault on A", 16'h5555, 1'b0, 2'b10);
    chk_cnt("R2 header fault on A");
    good_both(16'h4545);

    t = ~t;
    send(1'b1, 1'b1, mkf(16'h6161, t, 1'b0, 1'b0), mkf(16'h6666, t, 1'b1, 1'b0), -1);
    cb++;
    chk_out("R4 crc fault on B", 16'h6161, 1'b0, 2'b01);
    chk_cnt("R2 crc fault on B");
    good_both(16'h7777);

    t = ~t;
    send(1'b1, 1'b1, mkf(16'h8888, t, 1'b0, 1'b0), mkf(16'h8787, t, 1'b0, 1'b0), 20);
    ca++;
    chk_out("R1 coding violation on A", 16'h8787, 1'b0, 2'b10);
    chk_cnt("R1 coding violation on A");
    good_both(16'h9999);

    t = ~t;
    send(1'b1, 1'b1, mkf(16'h1234, t, 1'b1, 1'b0), mkf(16'h4321, t, 1'b1, 1'b0), -1);
    ca++; cb++;
    chk_out("R6 both faulty hold", 16'h9999, 1'b0, 2'b00);
    chk_cnt("R6 both faulty");
    good_both(16'hABCD);

    for (int k = 0; k < 4; k++) begin
      t = ~t;
      send(1'b0, 1'b1, 32'h0, mkf(16'h1111, t, 1'b0, 1'b0), -1);
    end
    ca++;
    chk_out("R3 silence on A", 16'h1111, 1'b0, 2'b10);
    chk_cnt("R3 silence on A");
    good_both(16'h2468);
    chk_out("R4 A back after silence", 16'h2468, 1'b0, 2'b01);

    for (int k = 0; k < 15; k++)
      send(1'b1, 1'b1, mkf(16'h5555, t, 1'b0, 1'b0), mkf(16'h5A5A, t, 1'b0, 1'b0), -1);
    ct++;
    chk_out("R7 toggle stuck", 16'hFFFF, 1'b1, 2'b11);
    chk_cnt("R7 toggle stuck");
    good_both(16'h6666);
    chk_out("R7 toggle resumed", 16'h6666, 1'b0, 2'b01);

    repeat (22000) @(negedge clk);
    ca += 22; cb += 22; ct += 5;
    chk_out("R7 override on dead lines", 16'hFFFF, 1'b1, 2'b11);
    chk_cnt("R8 saturation");

    good_both(16'h0F0F);
    chk_out("R7 R4 recovery", 16'h0F0F, 1'b0, 2'b01);
    chk_cnt("R8 no wrap");

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule